// File: doc/BRIEF.md
# Parallel ATA Device Register Front End

This block is the device-side front end that a parallel ATA host sees for programmed I/O. The host drives an active-low chip select for the command block, a second active-low chip select for the control block, a 3-bit register address, and active-low read and write strobes. The block brings both strobes into the device clock domain and commits a write on the trailing (rising) edge of the write strobe. It serves the byte-wide task-file registers on the low byte lane and a 16-bit data port on the full bus.

On the device side it presents the stored task-file parameters, a one-cycle command pulse with its opcode, an interrupt-request input and a status byte. Two valid/ready FIFO handshakes carry the data port: one for words written by the host and one for words the host will read. A ready output is pulled low to stretch the host cycle in two cases: a data-port read is waiting for a word, or a data-port strobe arrives while the previous written word is still draining. An interrupt-disable bit in the device-control register masks the active-high interrupt output.

The data-port sequencer has four states. DP_IDLE goes to DP_WR_DRAIN on a data-port write edge, and to DP_RD_FETCH while a data-port read strobe is held. DP_RD_FETCH goes to DP_RD_HOLD when a word is popped, and back to DP_IDLE if the strobe is released. DP_RD_HOLD returns to DP_IDLE when the read strobe is released. DP_WR_DRAIN returns to DP_IDLE when the consumer accepts the word.

Top module: `pata_reg_front`

## Requirements
- R1: After `host_rst_n` is low, the following hold until the host acts:
  - `tf_block` is zero, and `intrq`, `bus_oe`, `wf_valid`, `cmd_valid` and `rf_pop` are 0.
  - `ready` is 1.
- R2: With `cs_n` low, a write to address 1 to 6 stores `bus_in[7:0]` in the byte `tf_block[8*(a-1) +: 8]` and ignores `bus_in[15:8]`. A read of address 1 to 6 returns that byte in `bus_out[7:0]`, with `bus_out[15:8]` zero.
- R3: A write is committed only after the rising edge of `wr_n`. While `wr_n` stays low, the targeted register keeps its old value.
- R4: Strobes with both `cs_n` and `ctl_cs_n` high change no register and produce no command pulse.
- R5: `bus_oe` is 1 exactly when `rd_n` is low and either `cs_n` or `ctl_cs_n` is low.
- R6: With `cs_n` low, a write to address 0 presents all 16 bits on `wf_data` with `wf_valid` held until `wf_ready`. While that word is pending, a new data-port strobe sees `ready` low.
- R7: A data-port read (`cs_n` low, address 0) holds `ready` low until a word is available on `rf_valid`. It then pops exactly one word and returns all 16 bits on `bus_out`.
- R8: With `cs_n` low, a write to address 7 gives a one-cycle `cmd_valid` with `cmd_byte` equal to the written low byte, and clears a pending interrupt.
- R9: `irq_set` makes an interrupt pending. `intrq` is high only while one is pending and bit 1 of the device-control register is 0. The device-control register is written through `ctl_cs_n` low, address 6.
- R10: A read at `cs_n` low, address 7 returns `dev_status` and clears a pending interrupt. A read at `ctl_cs_n` low, address 6 returns `dev_status` and leaves the interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| host_rst_n | input | 1 | Active-low hardware reset from the host |
| cs_n | input | 1 | Active-low command-block select |
| ctl_cs_n | input | 1 | Active-low control-block select |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_in | input | 16 | Host data toward the device |
| bus_out | output | 16 | Device data toward the host |
| bus_oe | output | 1 | Drive enable for the bidirectional pad |
| ready | output | 1 | Low stretches the host cycle |
| intrq | output | 1 | Active-high interrupt request |
| cmd_valid | output | 1 | One-cycle pulse for a command write |
| cmd_byte | output | 8 | Opcode of the last command |
| tf_block | output | 48 | Task-file parameter bytes, address 1 in the low byte |
| dev_status | input | 8 | Status byte returned to host reads |
| irq_set | input | 1 | Internal request to raise an interrupt |
| wf_valid | output | 1 | Written data-port word pending |
| wf_data | output | 16 | Written data-port word |
| wf_ready | input | 1 | Consumer accepts the pending word |
| rf_valid | input | 1 | Read-side word available |
| rf_data | input | 16 | Read-side word |
| rf_pop | output | 1 | Read-side word consumed |

## Verification
Two situations are hard to reach. The first is a second data-port write landing while the first word is still pending. The bench reaches it by holding `wf_ready` low, finishing one write, and then lowering `wr_n` again before releasing the consumer. The second is a read that must wait for data. The bench runs a data-port read against an empty read-side source alongside a parallel thread; that thread checks `ready` partway through the stretched cycle and only then supplies the word. A scoreboard queue holds the expected read values pushed by the host task, and a monitor compares them against the bus as each read completes.

// File: rtl/pata_fe_pkg.sv
package pata_fe_pkg;

    // data-port sequencer states
    typedef enum logic [1:0] {
        DP_IDLE,
        DP_RD_FETCH,
        DP_RD_HOLD,
        DP_WR_DRAIN
    } dp_state_e;

    // interrupt-disable bit position inside the device-control byte
    localparam int NIEN_BIT = 1;

    // number of strobes brought into the clock domain (read, write)
    localparam int NUM_STROBES = 2;

endpackage

// File: rtl/pata_strobe_sync.sv
module pata_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic active,
    output logic rise
);

    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], strobe_n};
        end
    end

    assign active = ~chain_q[STAGES-1];
    assign rise   = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pata_taskfile.sv
module pata_taskfile #(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8,
    localparam int NUM_PARAM = (2 ** ADDR_W) - 2,
    localparam int TF_W      = NUM_PARAM * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_ctl,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              stat_ack,
    input  logic              irq_set,
    input  logic [BYTE_W-1:0] dev_status,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [TF_W-1:0]   tf_block,
    output logic              nien,
    output logic              irq_pend,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte
);

    localparam int CMD_ADR = (2 ** ADDR_W) - 1;
    localparam int CTL_ADR = (2 ** ADDR_W) - 2;

    logic [TF_W-1:0] tf_q;
    logic            cmd_hit;
    logic            ctl_hit;

    assign cmd_hit = wr_en && !wr_ctl && (wr_addr == ADDR_W'(CMD_ADR));
    assign ctl_hit = wr_en &&  wr_ctl && (wr_addr == ADDR_W'(CTL_ADR));

    // parameter bytes at addresses 1 .. NUM_PARAM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tf_q <= '0;
        end else if (wr_en && !wr_ctl) begin
            for (int i = 1; i <= NUM_PARAM; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    tf_q[(i-1)*BYTE_W +: BYTE_W] <= wr_byte;
                end
            end
        end
    end

    // device-control: only the interrupt-disable bit is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nien <= 1'b0;
        end else if (ctl_hit) begin
            nien <= wr_byte[pata_fe_pkg::NIEN_BIT];
        end
    end

    // command pulse and opcode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
        end else begin
            cmd_valid <= cmd_hit;
            if (cmd_hit) begin
                cmd_byte <= wr_byte;
            end
        end
    end

    // pending interrupt: a new request wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
        end else if (irq_set) begin
            irq_pend <= 1'b1;
        end else if (cmd_hit || stat_ack) begin
            irq_pend <= 1'b0;
        end
    end

    always_comb begin
        rd_byte = '0;
        if (rd_ctl) begin
            if (rd_addr == ADDR_W'(CTL_ADR)) begin
                rd_byte = dev_status;
            end
        end else if (rd_addr == ADDR_W'(CMD_ADR)) begin
            rd_byte = dev_status;
        end else begin
            for (int i = 1; i <= NUM_PARAM; i++) begin
                if (rd_addr == ADDR_W'(i)) begin
                    rd_byte = tf_q[(i-1)*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign tf_block = tf_q;

endmodule

// File: rtl/pata_dport.sv
module pata_dport #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic              wr_active,
    input  logic              wr_rise,
    input  logic              dp_sel_q,
    input  logic              dp_rd_raw,
    input  logic              dp_any_raw,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rf_valid,
    input  logic [DATA_W-1:0] rf_data,
    input  logic              wf_ready,
    output logic              rf_pop,
    output logic [DATA_W-1:0] rd_word,
    output logic              wf_valid,
    output logic [DATA_W-1:0] wf_data,
    output logic              ready
);

    import pata_fe_pkg::*;

    dp_state_e state_q, state_d;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] wf_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DP_IDLE: begin
                if (wr_rise && dp_sel_q) begin
                    state_d = DP_WR_DRAIN;
                end else if (rd_active && !wr_active && dp_sel_q) begin
                    state_d = DP_RD_FETCH;
                end
            end
            DP_RD_FETCH: begin
                if (!rd_active) begin
                    state_d = DP_IDLE;
                end else if (rf_valid) begin
                    state_d = DP_RD_HOLD;
                end
            end
            DP_RD_HOLD: begin
                if (!rd_active) begin
                    state_d = DP_IDLE;
                end
            end
            DP_WR_DRAIN: begin
                if (wf_ready) begin
                    state_d = DP_IDLE;
                end
            end
            default: state_d = DP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rf_pop   = (state_q == DP_RD_FETCH) && rd_active && rf_valid;
        wf_valid = (state_q == DP_WR_DRAIN);
        ready    = !((dp_rd_raw && state_q != DP_RD_HOLD) ||
                     (dp_any_raw && state_q == DP_WR_DRAIN));
    end

    // word holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            wf_q <= '0;
        end else begin
            if (rf_pop) begin
                rd_q <= rf_data;
            end
            if (state_q == DP_IDLE && wr_rise && dp_sel_q) begin
                wf_q <= wr_word;
            end
        end
    end

    assign rd_word = rd_q;
    assign wf_data = wf_q;

endmodule

// File: rtl/pata_reg_front.sv
module pata_reg_front #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int TF_W = ((2 ** ADDR_W) - 2) * BYTE_W
) (
    input  logic              clk,
    input  logic              host_rst_n,
    input  logic              cs_n,
    input  logic              ctl_cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              ready,
    output logic              intrq,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic [TF_W-1:0]   tf_block,
    input  logic [BYTE_W-1:0] dev_status,
    input  logic              irq_set,
    output logic              wf_valid,
    output logic [DATA_W-1:0] wf_data,
    input  logic              wf_ready,
    input  logic              rf_valid,
    input  logic [DATA_W-1:0] rf_data,
    output logic              rf_pop
);

    import pata_fe_pkg::*;

    localparam int CMD_ADR = (2 ** ADDR_W) - 1;
    localparam int RD_IDX  = 0;
    localparam int WR_IDX  = 1;

    logic [NUM_STROBES-1:0] strb_n;
    logic [NUM_STROBES-1:0] strb_act;
    logic [NUM_STROBES-1:0] strb_rise;

    assign strb_n[RD_IDX] = rd_n;
    assign strb_n[WR_IDX] = wr_n;

    genvar g;
    generate
        for (g = 0; g < NUM_STROBES; g++) begin : g_sync
            pata_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (host_rst_n),
                .strobe_n (strb_n[g]),
                .active   (strb_act[g]),
                .rise     (strb_rise[g])
            );
        end
    endgenerate

    // bus capture while a strobe is low; the last low-cycle sample is kept
    logic              cs_q;
    logic              ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;

    always_ff @(posedge clk or negedge host_rst_n) begin
        if (!host_rst_n) begin
            cs_q   <= 1'b1;
            ctl_q  <= 1'b1;
            addr_q <= '0;
            wdat_q <= '0;
        end else begin
            if (!rd_n || !wr_n) begin
                cs_q   <= cs_n;
                ctl_q  <= ctl_cs_n;
                addr_q <= addr;
            end
            if (!wr_n) begin
                wdat_q <= bus_in;
            end
        end
    end

    logic dp_sel_q;
    logic dp_sel_raw;
    logic dp_rd_raw;
    logic dp_any_raw;
    logic tf_wr_en;
    logic stat_ack;

    assign dp_sel_q   = !cs_q && (addr_q == '0);
    assign dp_sel_raw = !cs_n && (addr == '0);
    assign dp_rd_raw  = dp_sel_raw && !rd_n;
    assign dp_any_raw = dp_sel_raw && (!rd_n || !wr_n);
    assign tf_wr_en   = strb_rise[WR_IDX] && (!cs_q || !ctl_q) && !dp_sel_q;
    assign stat_ack   = strb_rise[RD_IDX] && !cs_q && (addr_q == ADDR_W'(CMD_ADR));

    logic [BYTE_W-1:0] rd_byte;
    logic              nien;
    logic              irq_pend;

    pata_taskfile #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_tf (
        .clk        (clk),
        .rst_n      (host_rst_n),
        .wr_en      (tf_wr_en),
        .wr_ctl     (cs_q),
        .wr_addr    (addr_q),
        .wr_byte    (wdat_q[BYTE_W-1:0]),
        .rd_ctl     (cs_n),
        .rd_addr    (addr),
        .stat_ack   (stat_ack),
        .irq_set    (irq_set),
        .dev_status (dev_status),
        .rd_byte    (rd_byte),
        .tf_block   (tf_block),
        .nien       (nien),
        .irq_pend   (irq_pend),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte)
    );

    logic [DATA_W-1:0] rd_word;

    pata_dport #(.DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (host_rst_n),
        .rd_active  (strb_act[RD_IDX]),
        .wr_active  (strb_act[WR_IDX]),
        .wr_rise    (strb_rise[WR_IDX]),
        .dp_sel_q   (dp_sel_q),
        .dp_rd_raw  (dp_rd_raw),
        .dp_any_raw (dp_any_raw),
        .wr_word    (wdat_q),
        .rf_valid   (rf_valid),
        .rf_data    (rf_data),
        .wf_ready   (wf_ready),
        .rf_pop     (rf_pop),
        .rd_word    (rd_word),
        .wf_valid   (wf_valid),
        .wf_data    (wf_data),
        .ready      (ready)
    );

    assign bus_oe  = (!cs_n || !ctl_cs_n) && !rd_n;
    assign bus_out = dp_sel_raw ? rd_word : {{(DATA_W-BYTE_W){1'b0}}, rd_byte};
    assign intrq   = irq_pend && !nien;

endmodule

// File: rtl/pata_reg_front_chk.sv
module pata_reg_front_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              wf_valid,
    input logic              wf_ready,
    input logic [DATA_W-1:0] wf_data,
    input logic              rf_pop,
    input logic              ready
);

    // R8
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6
    wf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_valid && !wf_ready) |=> (wf_valid && $stable(wf_data)));

    // R7
    pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_pop |=> !rf_pop);

    // R7
    pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_pop |=> ready);

endmodule

bind pata_reg_front pata_reg_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (host_rst_n),
    .cmd_valid (cmd_valid),
    .wf_valid  (wf_valid),
    .wf_ready  (wf_ready),
    .wf_data   (wf_data),
    .rf_pop    (rf_pop),
    .ready     (ready)
);

// File: tb/pata_reg_front_bench.sv
module pata_reg_front_bench;

    logic        clk = 1'b0;
    logic        host_rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        ctl_cs_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic        ready;
    logic        intrq;
    logic        cmd_valid;
    logic [7:0]  cmd_byte;
    logic [47:0] tf_block;
    logic [7:0]  dev_status = 8'h50;
    logic        irq_set = 1'b0;
    logic        wf_valid;
    logic [15:0] wf_data;
    logic        wf_ready = 1'b0;
    logic        rf_valid = 1'b0;
    logic [15:0] rf_data = '0;
    logic        rf_pop;

    always #2 clk = ~clk;

    pata_reg_front u_pata_reg_front (
        .clk(clk), .host_rst_n(host_rst_n), .cs_n(cs_n), .ctl_cs_n(ctl_cs_n),
        .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .ready(ready), .intrq(intrq),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .tf_block(tf_block),
        .dev_status(dev_status), .irq_set(irq_set), .wf_valid(wf_valid),
        .wf_data(wf_data), .wf_ready(wf_ready), .rf_valid(rf_valid),
        .rf_data(rf_data), .rf_pop(rf_pop)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard for host reads
    typedef struct {
        string       req;
        logic [15:0] val;
    } exp_t;
    exp_t        exp_q[$];
    logic        mon_take = 1'b0;
    logic [15:0] mon_val = '0;

    always @(posedge clk) begin : monitor
        exp_t e;
        if (mon_take) begin
            mon_take = 1'b0;
            if (exp_q.size() == 0) begin
                check("scoreboard empty", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(e.req, mon_val, e.val);
            end
        end
    end

    // read-side word source
    logic [15:0] rf_src[$];
    int          pops = 0;
    always @(posedge clk) begin
        if (rf_pop && rf_src.size() > 0) begin
            void'(rf_src.pop_front());
            pops++;
        end
        rf_valid <= (rf_src.size() > 0);
        rf_data  <= (rf_src.size() > 0) ? rf_src[0] : 16'h0;
    end

    // write-side collector and command monitor
    logic [15:0] wf_got[$];
    int          cmd_cnt = 0;
    logic [7:0]  last_cmd = '0;
    always @(posedge clk) begin
        if (wf_valid && wf_ready) wf_got.push_back(wf_data);
        if (cmd_valid) begin
            cmd_cnt++;
            last_cmd = cmd_byte;
        end
    end

    task automatic select(input bit ctl, input logic [2:0] a);
        cs_n     = ctl;
        ctl_cs_n = !ctl;
        addr     = a;
    endtask

    task automatic deselect();
        cs_n     = 1'b1;
        ctl_cs_n = 1'b1;
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!ready && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic host_write(input bit ctl, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        select(ctl, a);
        bus_in = d;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wait_ready();
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        deselect();
        @(negedge clk);
    endtask

    task automatic host_read(input bit ctl, input logic [2:0] a,
                             input logic [15:0] exp, input string req);
        exp_q.push_back('{req, exp});
        @(negedge clk);
        select(ctl, a);
        @(negedge clk);
        rd_n = 1'b0;
        repeat (2) @(negedge clk);
        wait_ready();
        repeat (2) @(negedge clk);
        mon_val  = bus_out;
        mon_take = 1'b1;
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        deselect();
        @(negedge clk);
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_set = 1'b1;
        @(negedge clk);
        irq_set = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [47:0] exp_tf;
        int          c0;

        repeat (5) @(negedge clk);
        host_rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 tf_block", tf_block, 48'h0);
        check("R1 intrq", intrq, 0);
        check("R1 ready", ready, 1);
        check("R1 bus_oe", bus_oe, 0);
        check("R1 wf_valid", wf_valid, 0);
        check("R1 cmd_valid", cmd_valid, 0);
        check("R1 rf_pop", rf_pop, 0);

        // R2 byte-lane writes with junk in the upper byte, then readback
        exp_tf = '0;
        for (int a = 1; a <= 6; a++) begin
            host_write(0, 3'(a), {8'hA5, 8'(8'h10 * a + a)});
            exp_tf[(a-1)*8 +: 8] = 8'(8'h10 * a + a);
        end
        check("R2 tf_block", tf_block, exp_tf);
        for (int a = 1; a <= 6; a++) begin
            host_read(0, 3'(a), {8'h00, 8'(8'h10 * a + a)}, "R2 readback");
        end

        // R3 commit only on the trailing edge
        @(negedge clk);
        select(0, 3'd2);
        bus_in = 16'h0077;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R3 held before trailing edge", tf_block[15:8], 8'h22);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        deselect();
        check("R3 committed after trailing edge", tf_block[15:8], 8'h77);
        exp_tf[15:8] = 8'h77;

        // R4 strobes without any chip select
        c0 = cmd_cnt;
        for (int a = 3; a <= 7; a += 4) begin
            @(negedge clk);
            deselect();
            addr   = 3'(a);
            bus_in = 16'h00FF;
            @(negedge clk);
            wr_n = 1'b0;
            repeat (3) @(negedge clk);
            wr_n = 1'b1;
            repeat (6) @(negedge clk);
        end
        check("R4 registers unchanged", tf_block, exp_tf);
        check("R4 no command", cmd_cnt, c0);

        // R5 output enable
        @(negedge clk);
        deselect();
        addr = 3'd1;
        rd_n = 1'b0;
        @(negedge clk);
        check("R5 oe no select", bus_oe, 0);
        cs_n = 1'b0;
        @(negedge clk);
        check("R5 oe cs and rd", bus_oe, 1);
        rd_n = 1'b1;
        @(negedge clk);
        check("R5 oe cs only", bus_oe, 0);
        cs_n = 1'b1;
        ctl_cs_n = 1'b0;
        addr = 3'd6;
        rd_n = 1'b0;
        @(negedge clk);
        check("R5 oe ctl and rd", bus_oe, 1);
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        deselect();

        // R8 command pulse
        c0 = cmd_cnt;
        host_write(0, 3'd7, 16'h33EC);
        check("R8 one pulse", cmd_cnt, c0 + 1);
        check("R8 opcode", last_cmd, 8'hEC);

        // R9 interrupt masking
        pulse_irq();
        check("R9 intrq set", intrq, 1);
        host_write(1, 3'd6, 16'h0002);
        check("R9 intrq masked", intrq, 0);
        host_write(1, 3'd6, 16'h0000);
        check("R9 intrq unmasked", intrq, 1);

        // R10 alternate status keeps, status clears
        dev_status = 8'h58;
        host_read(1, 3'd6, 16'h0058, "R10 alt status");
        check("R10 alt read keeps irq", intrq, 1);
        host_read(0, 3'd7, 16'h0058, "R10 status");
        check("R10 status read clears irq", intrq, 0);

        // R8 command write clears the pending interrupt
        pulse_irq();
        check("R8 irq pending before command", intrq, 1);
        host_write(0, 3'd7, 16'h0030);
        check("R8 command clears irq", intrq, 0);

        // R6 data-port write with a stalled consumer
        wf_ready = 1'b0;
        host_write(0, 3'd0, 16'hBEEF);
        check("R6 wf_valid", wf_valid, 1);
        check("R6 wf_data", wf_data, 16'hBEEF);
        @(negedge clk);
        select(0, 3'd0);
        bus_in = 16'h1234;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R6 ready stretched", ready, 0);
        check("R6 word held", wf_data, 16'hBEEF);
        wf_ready = 1'b1;
        wait_ready();
        wr_n = 1'b1;
        repeat (8) @(negedge clk);
        deselect();
        wf_ready = 1'b0;
        check("R6 words written", wf_got.size(), 2);
        if (wf_got.size() == 2) begin
            check("R6 first word", wf_got[0], 16'hBEEF);
            check("R6 second word", wf_got[1], 16'h1234);
        end
        check("R6 drained", wf_valid, 0);

        // R7 data-port read waiting on an empty source
        fork
            host_read(0, 3'd0, 16'hA55A, "R7 late word");
            begin
                repeat (12) @(negedge clk);
                check("R7 ready stretched", ready, 0);
                rf_src.push_back(16'hA55A);
            end
        join
        check("R7 one pop", pops, 1);
        rf_src.push_back(16'h0F0F);
        rf_src.push_back(16'hF0F0);
        repeat (3) @(negedge clk);
        host_read(0, 3'd0, 16'h0F0F, "R7 first queued word");
        host_read(0, 3'd0, 16'hF0F0, "R7 second queued word");
        check("R7 pop per read", pops, 3);

        repeat (4) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule